// File: doc/BRIEF.md
# Two-Plane Flash Command Controller with Fast-Program Mode

This block sits in front of a two-plane flash-style word array and turns a stream of write cycles into program and erase operations. Multi-cycle unlock sequences select a single-word program or a sector erase. The controller records which plane is running an operation. It lets reads reach the plane that is idle, and it can hold a running erase so that other sectors can be read or programmed. A read that targets a plane with a running operation returns a status word instead of array data. Software polls that word until the operation finishes.

A separate six-cycle sequence, accepted only while the high-voltage indication is asserted, latches a fast-program mode. In that mode every write cycle is one program operation and no command code is decoded. The mode stays set until reset, or until the high-voltage indication falls. The array is modelled by small per-plane memories, and program and erase take fixed cycle counts. Programming can only clear bits: the new word is the AND of the stored word and the written data. Erase sets every word of a sector to all ones.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A read of a plane with no running operation returns the stored word one cycle later, even while the other plane is busy.
- R2: The sequence AA@555, 55@2AA, A0@555 followed by a data write programs that word. The plane's busy bit is high for exactly PROG_CYC cycles, and the stored word then becomes old AND data.
- R3: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 30@sector starts a sector erase. Address bits 5:4 select the sector of 16 words. The plane stays busy for ERASE_CYC cycles, and every word of that sector then reads FFFF.
- R4: A read of a busy plane returns a status word. Bit 7 is the complement of bit 7 of the word being written: the program data, or 0 during an erase. Bit 6 flips on every status read and is 0 for the first read after reset. All other bits are 0.
- R5: Writing B0 while an erase runs holds it: erase_held goes high and the plane leaves busy. While the erase is held, a program to another sector is accepted and a program into the held sector is dropped. Writing 30 resumes the held erase, which then finishes.
- R6: A write that does not match the expected step returns the sequence to its start without side effects. A program or erase requested while another operation runs is dropped.
- R7: The sequence AA@555, 55@2AA, 20@555, AA@555, 55@2AA, C0@555 sets fast_mode only if vpp_hi is high on its last cycle.
- R8: In fast mode a single write programs the addressed word, with the same busy period as R2.
- R9: Fast mode is cleared by rst and by a falling vpp_hi. Writing F0 does not clear it.
- R10: In fast mode the codes 30, B0 and F0 are programmed as data and are not decoded as commands.
- R11: After reset, rdata is 0, busy is 00, erase_held is 0 and fast_mode is 0.
- R12: At most one plane is busy in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 20 | Word address; bit 19 selects the plane |
| wdata | input | 16 | Write data; bits 7:0 carry command codes |
| vpp_hi | input | 1 | High-voltage programming indication |
| rdata | output | 16 | Read data or status word, valid the cycle after rd_en |
| busy | output | 2 | One bit per plane: an operation runs there |
| erase_held | output | 1 | An erase is suspended |
| fast_mode | output | 1 | Fast-program mode is latched |

## Verification
A wrong sequence state shows up at the ports in one of two ways. Either a program or erase that should start leaves busy low in the cycle after the final write, or a stray one raises busy there. A wrong operation counter shortens or stretches the busy window, or changes the stored word that the next plain read returns. A wrong toggle or polling bit appears on the very next status read. A mode latch error appears when fast_mode changes one cycle after the vpp_hi edge or sequence end that should or should not have changed it. A reference model is compared against the ports every cycle, so each fault is seen within one cycle of the point where it becomes visible.

// File: rtl/flash_pkg.sv
package flash_pkg;
  // Sequencer states for the write-cycle command decoder
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PDATA,
    SQ_E1, SQ_E2, SQ_E3,
    SQ_F1, SQ_F2, SQ_F3
  } seq_t;

  // Command codes carried on the low data byte
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_SECTOR = 8'h30;
  localparam logic [7:0] OP_HOLD   = 8'hB0;
  localparam logic [7:0] OP_RESUME = 8'h30;
  localparam logic [7:0] OP_FAST1  = 8'h20;
  localparam logic [7:0] OP_FAST2  = 8'hC0;

  // Status word bit positions
  localparam int ST_POLL = 7;
  localparam int ST_TOG  = 6;
endpackage

// File: rtl/flash_plane_mem.sv
module flash_plane_mem #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              a_re,
  input  logic [MEM_AW-1:0] a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_we,
  input  logic [MEM_AW-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Array powers up erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // Port A: user read, read-first
  always_ff @(posedge clk) begin
    if (a_re) a_q <= mem[a_addr];
  end

  // Port B: engine read/write, read-first
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int          UL_AW = 11,
  parameter logic [10:0] UL_A1 = 11'h555,
  parameter logic [10:0] UL_A2 = 11'h2AA,
  parameter logic [7:0]  UL_D1 = 8'hAA,
  parameter logic [7:0]  UL_D2 = 8'h55
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             bypass,
  input  logic [UL_AW-1:0] a_lo,
  input  logic [7:0]       code,
  input  logic             vpp_hi,
  output logic             prog_req,
  output logic             erase_req,
  output logic             hold_req,
  output logic             resume_req,
  output logic             fast_set
);
  seq_t st, st_nx;
  logic at_a1, at_a2, step1, step2;

  assign at_a1 = (a_lo == UL_A1[UL_AW-1:0]);
  assign at_a2 = (a_lo == UL_A2[UL_AW-1:0]);
  assign step1 = at_a1 && (code == UL_D1);
  assign step2 = at_a2 && (code == UL_D2);

  always_comb begin
    st_nx      = st;
    prog_req   = 1'b0;
    erase_req  = 1'b0;
    hold_req   = 1'b0;
    resume_req = 1'b0;
    fast_set   = 1'b0;
    if (wr_en && !bypass) begin
      st_nx = SQ_IDLE;
      unique case (st)
        SQ_IDLE: begin
          if (step1)                   st_nx = SQ_U1;
          else if (code == OP_HOLD)    hold_req = 1'b1;
          else if (code == OP_RESUME)  resume_req = 1'b1;
        end
        SQ_U1: if (step2) st_nx = SQ_U2;
        SQ_U2: begin
          if (at_a1) begin
            if (code == OP_PROG)       st_nx = SQ_PDATA;
            else if (code == OP_ERASE) st_nx = SQ_E1;
            else if (code == OP_FAST1) st_nx = SQ_F1;
          end
        end
        SQ_PDATA: prog_req = 1'b1;
        SQ_E1: if (step1) st_nx = SQ_E2;
        SQ_E2: if (step2) st_nx = SQ_E3;
        SQ_E3: if (code == OP_SECTOR) erase_req = 1'b1;
        SQ_F1: if (step1) st_nx = SQ_F2;
        SQ_F2: if (step2) st_nx = SQ_F3;
        SQ_F3: if (at_a1 && code == OP_FAST2 && vpp_hi) fast_set = 1'b1;
        default: st_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bypass) st <= SQ_IDLE;
    else               st <= st_nx;
  end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_AW    = 6,
  parameter int SEC_AW    = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   prog_req,
  input  logic                   erase_req,
  input  logic                   hold_req,
  input  logic                   resume_req,
  input  logic                   req_plane,
  input  logic [MEM_AW-1:0]      req_idx,
  input  logic [DATA_W-1:0]      req_data,
  input  logic                   rd_en,
  input  logic                   rd_plane,
  input  logic [1:0][DATA_W-1:0] pb_q,
  output logic [1:0]             pb_we,
  output logic [MEM_AW-1:0]      pb_addr,
  output logic [DATA_W-1:0]      pb_wd,
  output logic                   st_sel,
  output logic [DATA_W-1:0]      st_word,
  output logic [1:0]             busy,
  output logic                   erase_held
);
  localparam int SEC_BITS = MEM_AW - SEC_AW;
  localparam int SEC_W    = 1 << SEC_AW;
  localparam int PCW      = $clog2(PROG_CYC + 1);
  localparam int ECW      = $clog2(ERASE_CYC + 1);

  // Program context
  logic              pg_act, pg_pl;
  logic [MEM_AW-1:0] pg_idx;
  logic [DATA_W-1:0] pg_dat;
  logic [PCW-1:0]    pg_cnt;
  // Erase context
  logic                er_act, er_hold, er_pl;
  logic [SEC_BITS-1:0] er_sec;
  logic [ECW-1:0]      er_cnt;

  logic er_run, pg_done, er_done, sweep;
  logic prog_ok, erase_ok, hold_ok, resume_ok, same_sec;
  logic rd_pg, rd_run, tog;

  assign er_run   = er_act && !er_hold;
  assign pg_done  = pg_act && (pg_cnt == PCW'(PROG_CYC - 1));
  assign er_done  = er_run && (er_cnt == ECW'(ERASE_CYC - 1));
  assign sweep    = er_run && (er_cnt < ECW'(SEC_W));
  assign same_sec = (req_plane == er_pl) && (req_idx[MEM_AW-1:SEC_AW] == er_sec);

  assign prog_ok   = prog_req && !pg_act && (!er_act || (er_hold && !same_sec));
  assign erase_ok  = erase_req && !pg_act && !er_act;
  assign hold_ok   = hold_req && er_run && !er_done;
  assign resume_ok = resume_req && er_hold && !pg_act;

  // Shared engine port: erase sweep or program read-modify-write
  assign pb_addr = er_run ? {er_sec, er_cnt[SEC_AW-1:0]} : pg_idx;
  assign pb_wd   = er_run ? '1 : (pg_dat & pb_q[pg_pl]);

  for (genvar p = 0; p < 2; p++) begin : g_pl
    assign pb_we[p] = (sweep && er_pl == 1'(p)) || (pg_done && pg_pl == 1'(p));
    assign busy[p]  = (pg_act && pg_pl == 1'(p)) || (er_run && er_pl == 1'(p));
  end

  assign erase_held = er_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_act <= 1'b0;
      pg_pl  <= 1'b0;
      pg_idx <= '0;
      pg_dat <= '0;
      pg_cnt <= '0;
    end else if (prog_ok) begin
      pg_act <= 1'b1;
      pg_pl  <= req_plane;
      pg_idx <= req_idx;
      pg_dat <= req_data;
      pg_cnt <= '0;
    end else if (pg_act) begin
      if (pg_done) pg_act <= 1'b0;
      else         pg_cnt <= pg_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      er_act  <= 1'b0;
      er_hold <= 1'b0;
      er_pl   <= 1'b0;
      er_sec  <= '0;
      er_cnt  <= '0;
    end else if (erase_ok) begin
      er_act  <= 1'b1;
      er_hold <= 1'b0;
      er_pl   <= req_plane;
      er_sec  <= req_idx[MEM_AW-1:SEC_AW];
      er_cnt  <= '0;
    end else begin
      if (er_run) begin
        if (er_done) er_act <= 1'b0;
        else         er_cnt <= er_cnt + 1'b1;
      end
      if (hold_ok)        er_hold <= 1'b1;
      else if (resume_ok) er_hold <= 1'b0;
    end
  end

  // Status word for reads of a busy plane
  assign rd_pg  = pg_act && (pg_pl == rd_plane);
  assign rd_run = rd_pg || (er_run && er_pl == rd_plane);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_sel  <= 1'b1;
      st_word <= '0;
      tog     <= 1'b0;
    end else if (rd_en) begin
      st_sel <= rd_run;
      if (rd_run) begin
        st_word          <= '0;
        st_word[ST_POLL] <= rd_pg ? ~pg_dat[7] : 1'b0;
        st_word[ST_TOG]  <= tog;
        tog              <= ~tog;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int          ADDR_W    = 20,
  parameter int          DATA_W    = 16,
  parameter int          MEM_AW    = 6,
  parameter int          SEC_AW    = 4,
  parameter int          PROG_CYC  = 4,
  parameter int          ERASE_CYC = 24,
  parameter int          UL_AW     = 11,
  parameter logic [10:0] UL_A1     = 11'h555,
  parameter logic [10:0] UL_A2     = 11'h2AA,
  parameter logic [7:0]  UL_D1     = 8'hAA,
  parameter logic [7:0]  UL_D2     = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vpp_hi,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        busy,
  output logic              erase_held,
  output logic              fast_mode
);
  localparam int PL_BIT = ADDR_W - 1;

  logic fast_q, vpp_q;
  logic s_prog, s_erase, s_hold, s_resume, s_fast;
  logic e_prog, rd_pl_q, st_sel;
  logic [DATA_W-1:0] st_word;
  logic [1:0] pb_we;
  logic [MEM_AW-1:0] pb_addr;
  logic [DATA_W-1:0] pb_wd;
  logic [1:0][DATA_W-1:0] pa_q, pb_q;
  logic unused_addr;

  assign unused_addr = ^addr[ADDR_W-2:UL_AW];

  flash_cmd_seq #(
    .UL_AW(UL_AW), .UL_A1(UL_A1), .UL_A2(UL_A2), .UL_D1(UL_D1), .UL_D2(UL_D2)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bypass(fast_q),
    .a_lo(addr[UL_AW-1:0]), .code(wdata[7:0]), .vpp_hi(vpp_hi),
    .prog_req(s_prog), .erase_req(s_erase), .hold_req(s_hold),
    .resume_req(s_resume), .fast_set(s_fast)
  );

  // Fast mode: every write is a program request, decoder bypassed
  assign e_prog = fast_q ? wr_en : s_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q <= 1'b0;
      vpp_q  <= 1'b0;
    end else begin
      vpp_q <= vpp_hi;
      if (vpp_q && !vpp_hi) fast_q <= 1'b0;
      else if (s_fast)      fast_q <= 1'b1;
    end
  end

  flash_op_engine #(
    .DATA_W(DATA_W), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst(rst),
    .prog_req(e_prog), .erase_req(s_erase), .hold_req(s_hold), .resume_req(s_resume),
    .req_plane(addr[PL_BIT]), .req_idx(addr[MEM_AW-1:0]), .req_data(wdata),
    .rd_en(rd_en), .rd_plane(addr[PL_BIT]),
    .pb_q(pb_q), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wd(pb_wd),
    .st_sel(st_sel), .st_word(st_word), .busy(busy), .erase_held(erase_held)
  );

  for (genvar p = 0; p < 2; p++) begin : g_mem
    flash_plane_mem #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
      .clk(clk), .a_re(rd_en), .a_addr(addr[MEM_AW-1:0]), .a_q(pa_q[p]),
      .b_we(pb_we[p]), .b_addr(pb_addr), .b_wd(pb_wd), .b_q(pb_q[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_pl_q <= 1'b0;
    else if (rd_en) rd_pl_q <= addr[PL_BIT];
  end

  assign rdata     = st_sel ? st_word : pa_q[rd_pl_q];
  assign fast_mode = fast_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              vpp_hi,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        busy,
  input logic              fast_mode
);
  // R12
  one_plane_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(busy) <= 1);

  // R7
  fast_needs_vpp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fast_mode) |-> $past(vpp_hi));

  // R9
  vpp_fall_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(vpp_hi) && !vpp_hi) |=> !fast_mode);

  // R9
  reset_exit_chk: assert property (@(posedge clk)
    rst |=> !fast_mode);

  // R4
  status_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy[addr[ADDR_W-1]]) |=> ((rdata & ~DATA_W'(16'h00C0)) == '0));

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy[addr[ADDR_W-1]] && !$past(rst) && $past(rd_en && busy[addr[ADDR_W-1]]))
      |=> (rdata[6] != $past(rdata[6])));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .vpp_hi(vpp_hi),
  .rdata(rdata), .busy(busy), .fast_mode(fast_mode)
);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
  localparam int PROG_N  = 4;
  localparam int ERASE_N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, vpp_hi = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  busy;
  logic        erase_held, fast_mode;

  int    n_vec = 0, n_bad = 0;
  bit    live = 1'b0, done = 1'b0;
  string tag = "R11";

  always #2 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .vpp_hi(vpp_hi), .rdata(rdata), .busy(busy),
    .erase_held(erase_held), .fast_mode(fast_mode)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_mem [2][64];
  logic [15:0] m_rd;
  int  m_seq, m_pg_cnt, m_er_cnt, m_pg_idx, m_er_sec;
  bit  m_pg, m_pg_pl, m_er, m_er_hold, m_er_pl, m_tog, m_fast, m_vpp;
  logic [15:0] m_pg_dat;

  initial begin
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 64; i++) m_mem[p][i] = 16'hFFFF;
  end

  function automatic logic [1:0] m_busy();
    logic [1:0] b;
    for (int p = 0; p < 2; p++)
      b[p] = (m_pg && m_pg_pl == p) || (m_er && !m_er_hold && m_er_pl == p);
    return b;
  endfunction

  always @(posedge clk) begin
    bit pa, ea, eh, erun, pdone, edone, p, a1, a2, s1, s2;
    bit preq, ereq, hreq, rreq, fset;
    int idx;
    logic [7:0] c;
    if (rst) begin
      m_rd = 16'h0; m_seq = 0; m_pg = 0; m_er = 0; m_er_hold = 0;
      m_tog = 0; m_fast = 0; m_vpp = 0;
    end else begin
      pa = m_pg; ea = m_er; eh = m_er_hold; erun = ea && !eh;
      pdone = pa && (m_pg_cnt == PROG_N - 1);
      edone = erun && (m_er_cnt == ERASE_N - 1);
      p = addr[19]; idx = int'(addr[5:0]);
      if (rd_en) begin
        if ((pa && m_pg_pl == p) || (erun && m_er_pl == p)) begin
          m_rd = 16'h0;
          m_rd[7] = (pa && m_pg_pl == p) ? ~m_pg_dat[7] : 1'b0;
          m_rd[6] = m_tog;
          m_tog = ~m_tog;
        end else m_rd = m_mem[p][idx];
      end
      preq = 0; ereq = 0; hreq = 0; rreq = 0; fset = 0;
      c = wdata[7:0];
      a1 = (addr[10:0] == 11'h555); a2 = (addr[10:0] == 11'h2AA);
      s1 = a1 && c == 8'hAA; s2 = a2 && c == 8'h55;
      if (m_fast) begin
        preq = wr_en; m_seq = 0;
      end else if (wr_en) begin
        case (m_seq)
          0: begin m_seq = s1 ? 1 : 0; if (!s1 && c == 8'hB0) hreq = 1; if (!s1 && c == 8'h30) rreq = 1; end
          1: m_seq = s2 ? 2 : 0;
          2: m_seq = !a1 ? 0 : (c == 8'hA0) ? 3 : (c == 8'h80) ? 4 : (c == 8'h20) ? 7 : 0;
          3: begin preq = 1; m_seq = 0; end
          4: m_seq = s1 ? 5 : 0;
          5: m_seq = s2 ? 6 : 0;
          6: begin ereq = (c == 8'h30); m_seq = 0; end
          7: m_seq = s1 ? 8 : 0;
          8: m_seq = s2 ? 9 : 0;
          9: begin fset = a1 && c == 8'hC0 && vpp_hi; m_seq = 0; end
          default: m_seq = 0;
        endcase
      end
      if (m_vpp && !vpp_hi) m_fast = 0;
      else if (fset) m_fast = 1;
      m_vpp = vpp_hi;
      if (erun) begin
        if (m_er_cnt < 16) m_mem[m_er_pl][m_er_sec * 16 + m_er_cnt] = 16'hFFFF;
        if (edone) m_er = 0; else m_er_cnt++;
      end
      if (pa) begin
        if (pdone) begin
          m_mem[m_pg_pl][m_pg_idx] = m_mem[m_pg_pl][m_pg_idx] & m_pg_dat;
          m_pg = 0;
        end else m_pg_cnt++;
      end
      if (preq && !pa && (!ea || (eh && !(p == m_er_pl && idx / 16 == m_er_sec)))) begin
        m_pg = 1; m_pg_pl = p; m_pg_idx = idx; m_pg_dat = wdata; m_pg_cnt = 0;
      end
      if (ereq && !pa && !ea) begin
        m_er = 1; m_er_hold = 0; m_er_pl = p; m_er_sec = idx / 16; m_er_cnt = 0;
      end
      if (hreq && erun && !edone) m_er_hold = 1;
      if (rreq && eh && !pa) m_er_hold = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (live) begin
      n_vec++;
      if (rdata !== m_rd || busy !== m_busy() || erase_held !== m_er_hold ||
          fast_mode !== m_fast) begin
        n_bad++;
        $display("FAIL %s rdata=%h/%h busy=%b/%b held=%b/%b fast=%b/%b (actual/expected)",
                 tag, rdata, m_rd, busy, m_busy(), erase_held, m_er_hold, fast_mode, m_fast);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string t, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [19:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seq_prog(logic [19:0] a, logic [15:0] d);
    wr(20'h555, 16'hAA); wr(20'h2AA, 16'h55); wr(20'h555, 16'hA0); wr(a, d);
  endtask

  task automatic seq_erase(logic [19:0] a);
    wr(20'h555, 16'hAA); wr(20'h2AA, 16'h55); wr(20'h555, 16'h80);
    wr(20'h555, 16'hAA); wr(20'h2AA, 16'h55); wr(a, 16'h30);
  endtask

  task automatic seq_fast();
    wr(20'h555, 16'hAA); wr(20'h2AA, 16'h55); wr(20'h555, 16'h20);
    wr(20'h555, 16'hAA); wr(20'h2AA, 16'h55); wr(20'h555, 16'hC0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    live = 1'b1;
    // R11 reset state
    tag = "R11";
    chk("R11 rdata", rdata, 16'h0);
    chk("R11 busy/held/fast", {13'b0, busy, erase_held}, 16'h0);
    chk("R11 fast", {15'b0, fast_mode}, 16'h0);

    // R2 program and R4 status polling
    tag = "R2";
    seq_prog(20'h00005, 16'h1234);
    tag = "R4";
    rd(20'h00005); chk("R4 first status", rdata, 16'h0080);
    rd(20'h00005); chk("R4 toggled status", rdata, 16'h00C0);
    tag = "R2";
    idle(3);
    chk("R2 busy cleared", {14'b0, busy}, 16'h0);
    rd(20'h00005); chk("R2 programmed word", rdata, 16'h1234);
    seq_prog(20'h00005, 16'hFF0F); idle(6);
    rd(20'h00005); chk("R2 AND with old word", rdata, 16'h1204);

    // R3 / R1 / R6: erase plane 1 sector 0
    tag = "R3";
    seq_prog(20'h80003, 16'h00FF); idle(6);
    seq_erase(20'h80000);
    chk("R3 erase busy", {14'b0, busy}, 16'h0002);
    tag = "R1";
    rd(20'h00005); chk("R1 idle plane read", rdata, 16'h1204);
    tag = "R4";
    rd(20'h80000); chk("R4 erase status", rdata, 16'h0000);
    rd(20'h80000); chk("R4 erase status toggled", rdata, 16'h0040);
    tag = "R6";
    seq_prog(20'h00020, 16'h0000);
    chk("R6 program during erase dropped", {14'b0, busy}, 16'h0002);

    // R5 suspend / resume
    tag = "R5";
    wr(20'h00000, 16'hB0);
    chk("R5 held", {15'b0, erase_held}, 16'h1);
    chk("R5 not busy while held", {14'b0, busy}, 16'h0);
    seq_prog(20'h80023, 16'hABCD);
    chk("R5 other-sector program accepted", {14'b0, busy}, 16'h0002);
    idle(6);
    seq_prog(20'h80001, 16'h0000);
    chk("R5 held-sector program dropped", {14'b0, busy}, 16'h0);
    wr(20'h00000, 16'h30);
    chk("R5 resumed", {14'b0, busy, erase_held}, 16'h0004);
    idle(30);
    chk("R5 erase finished", {13'b0, busy, erase_held}, 16'h0);
    rd(20'h80023); chk("R5 other sector kept", rdata, 16'hABCD);
    tag = "R3";
    rd(20'h80003); chk("R3 word erased", rdata, 16'hFFFF);
    rd(20'h80001); chk("R3 word erased 1", rdata, 16'hFFFF);
    tag = "R6";
    rd(20'h00020); chk("R6 dropped program left word", rdata, 16'hFFFF);

    // R6 broken sequence
    wr(20'h555, 16'hAA); wr(20'h2AA, 16'h12); wr(20'h555, 16'hA0); wr(20'h00007, 16'h0000);
    chk("R6 no busy after broken sequence", {14'b0, busy}, 16'h0);
    idle(5);
    rd(20'h00007); chk("R6 word untouched", rdata, 16'hFFFF);

    // R7 fast entry
    tag = "R7";
    vpp_hi = 1'b0;
    seq_fast(); idle(1);
    chk("R7 no entry without vpp", {15'b0, fast_mode}, 16'h0);
    vpp_hi = 1'b1; idle(1);
    seq_fast();
    chk("R7 entry with vpp", {15'b0, fast_mode}, 16'h1);

    // R8 single-write program
    tag = "R8";
    wr(20'h00009, 16'h5A5A);
    chk("R8 busy after one write", {14'b0, busy}, 16'h0001);
    idle(5);
    rd(20'h00009); chk("R8 programmed", rdata, 16'h5A5A);

    // R10 command codes programmed as data
    tag = "R10";
    wr(20'h0000A, 16'h0030); idle(5);
    wr(20'h0000B, 16'h00F0); idle(5);
    wr(20'h0000C, 16'h00B0); idle(5);
    rd(20'h0000A); chk("R10 code 30 as data", rdata, 16'h0030);
    rd(20'h0000B); chk("R10 code F0 as data", rdata, 16'h00F0);
    rd(20'h0000C); chk("R10 code B0 as data", rdata, 16'h00B0);
    tag = "R9";
    chk("R9 F0 keeps fast mode", {15'b0, fast_mode}, 16'h1);

    // R9 exits
    vpp_hi = 1'b0; idle(1);
    chk("R9 vpp fall exits", {15'b0, fast_mode}, 16'h0);
    vpp_hi = 1'b1; idle(1);
    seq_fast();
    chk("R9 re-entered", {15'b0, fast_mode}, 16'h1);
    live = 1'b0;
    rst = 1'b1; idle(1); rst = 1'b0;
    live = 1'b1;
    chk("R9 reset exits", {15'b0, fast_mode}, 16'h0);

    // R12 covered every cycle by the busy comparison; one explicit check
    tag = "R12";
    seq_prog(20'h80010, 16'h0F0F);
    chk("R12 single busy plane", {14'b0, busy}, 16'h0002);
    idle(6);

    done = 1'b1;
    finish_run();
  end
endmodule